// File: doc/BRIEF.md
# Sixteen-Line Bidirectional GPIO Port

This block gives a host on an 8-bit register bus control of sixteen general-purpose pins. Each pin can be an output or an input, and a direction bit set per line selects which. The sixteen lines are split into two byte lanes. Each lane has a data register and a direction register. The pad itself sits outside the block. The block drives an output-value vector and an output-enable vector, and it receives an input-value vector. Input levels pass through a two-stage synchronizer before any read can see them.

A second register gives an older, fixed-direction view of the same port. A write to it updates the low data byte, so it drives lines 0-7. A read from it returns the levels on lines 8-15. This view only makes sense while the direction registers hold their reset values, which are low byte all outputs and high byte all inputs. Writes take effect on a single-cycle write strobe. Read data is combinational from the address. The asynchronous active-low reset is released through an internal two-flop synchronizer, so registers leave reset two clock edges after the reset input rises.

Top module: `gpio16_port`

## Requirements
- R1: After reset the pin outputs are 0x0000 and the output enables are 0x00FF. Both data bytes read 0x00 while the pins are low. The direction byte for lines 0-7 (offset 0x406) reads 0xFF, and the direction byte for lines 8-15 (offset 0x407) reads 0x00.
- R2: A direction bit of 1 makes its line an output and a 0 makes it an input. Writing offset 0x406 (lines 0-7) or 0x407 (lines 8-15) sets `pin_oe` on the clock edge that accepts the write.
- R3: A write to offset 0x404 (lines 0-7) or 0x405 (lines 8-15) sets `pin_out` for every output line of that byte on the accepting edge. A read of that offset then returns the written bits.
- R4: A data write leaves alone the stored bit and `pin_out` of every line that is an input at the time of the write.
- R5: For input lines, a read of a data offset returns the level on `pin_in`. A change on `pin_in` becomes visible after exactly two clock edges.
- R6: A write to offset 0x400 updates the same storage as offset 0x404, with the same rule for input lines. The new value appears on `pin_out[7:0]` and when 0x404 is read.
- R7: A read of offset 0x400 returns the levels of lines 8-15, built the same way as a read of 0x405.
- R8: Any other address reads 0x00, and a write to it changes no register and no pin.
- R9: Direction bytes read back the value last written to them.
- R10: When a byte has lines in both directions, a data read merges the stored values of its output lines with the synchronized pin levels of its input lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Single-cycle write strobe |
| bus_rdata | output | 8 | Combinational read data |
| pin_out | output | 16 | Value driven on each line |
| pin_oe | output | 16 | Output enable per line, 1 means drive |
| pin_in | input | 16 | Level sensed on each line |

## Verification
A corrupted direction bit shows on `pin_oe` in the same cycle it is stored. It also changes what a data read returns for that line, because the read switches from the synchronized pin level to the stored value. A data bit that was wrongly updated while its line was an input stays hidden while the line remains an input. It shows on `pin_out` once the line is turned into an output, and the bench forces this by flipping direction after such writes. A synchronizer that is one stage too short or too long shows up as a read that changes one edge early or late. The bench therefore samples both edges after each change on `pin_in`.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned GPIO_BYTE_W = 8;
  typedef logic [GPIO_BYTE_W-1:0] gpio_byte_t;

  // Merge rule: output lines report the stored value, inputs the pin level.
  function automatic gpio_byte_t merge_level(gpio_byte_t stored,
                                              gpio_byte_t dir,
                                              gpio_byte_t sensed);
    return (stored & dir) | (sensed & ~dir);
  endfunction
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             srst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;
endmodule

// File: rtl/gpio_byte_lane.sv
module gpio_byte_lane
  import gpio_pkg::*;
#(
  parameter gpio_byte_t DIR_RST = '0
) (
  input  logic       clk,
  input  logic       srst_n,
  input  logic       data_we,
  input  logic       dir_we,
  input  gpio_byte_t wdata,
  output gpio_byte_t data_q,
  output gpio_byte_t dir_q
);
  gpio_byte_t data_d;
  gpio_byte_t dir_d;

  always_comb begin
    data_d = data_q;
    dir_d  = dir_q;
    // Only lines currently configured as outputs take the written bit.
    if (data_we) data_d = (data_q & ~dir_q) | (wdata & dir_q);
    if (dir_we)  dir_d  = wdata;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      data_q <= '0;
      dir_q  <= DIR_RST;
    end else begin
      if (data_we) data_q <= data_d;
      if (dir_we)  dir_q  <= dir_d;
    end
  end
endmodule

// File: rtl/gpio16_port.sv
module gpio16_port
  import gpio_pkg::*;
#(
  parameter int unsigned LINE_W   = 16,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned LEG_OFS  = 'h400,
  parameter int unsigned DATA_OFS = 'h404
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_we,
  output logic [7:0]        bus_rdata,
  output logic [LINE_W-1:0] pin_out,
  output logic [LINE_W-1:0] pin_oe,
  input  logic [LINE_W-1:0] pin_in
);
  localparam int unsigned NBYTES  = LINE_W / GPIO_BYTE_W;
  localparam int unsigned DIR_OFS = DATA_OFS + NBYTES;
  localparam int unsigned LEG_RD  = NBYTES - 1;

  logic              srst_n;
  logic [LINE_W-1:0] pin_sync;
  logic [NBYTES-1:0] sel_data;
  logic [NBYTES-1:0] sel_dir;
  logic              sel_leg;
  gpio_byte_t        data_b [NBYTES];
  gpio_byte_t        dir_b  [NBYTES];
  gpio_byte_t        lvl_b  [NBYTES];

  gpio_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .srst_n(srst_n));

  gpio_in_sync #(.WIDTH(LINE_W)) u_insync (
    .clk(clk), .srst_n(srst_n), .async_i(pin_in), .sync_o(pin_sync)
  );

  // Address decode
  always_comb begin
    sel_leg = (bus_addr == ADDR_W'(LEG_OFS));
    for (int k = 0; k < NBYTES; k++) begin
      sel_data[k] = (bus_addr == ADDR_W'(DATA_OFS + k));
      sel_dir[k]  = (bus_addr == ADDR_W'(DIR_OFS + k));
    end
  end

  for (genvar k = 0; k < NBYTES; k++) begin : g_lane
    localparam gpio_byte_t LANE_DIR_RST = (k == 0) ? '1 : '0;
    logic data_we;
    logic dir_we;

    // The legacy register aliases the lowest data byte.
    if (k == 0) begin : g_alias
      assign data_we = bus_we & (sel_data[k] | sel_leg);
    end else begin : g_plain
      assign data_we = bus_we & sel_data[k];
    end
    assign dir_we = bus_we & sel_dir[k];

    gpio_byte_lane #(.DIR_RST(LANE_DIR_RST)) u_lane (
      .clk    (clk),
      .srst_n (srst_n),
      .data_we(data_we),
      .dir_we (dir_we),
      .wdata  (bus_wdata),
      .data_q (data_b[k]),
      .dir_q  (dir_b[k])
    );

    assign lvl_b[k] = merge_level(data_b[k], dir_b[k],
                                  pin_sync[k*GPIO_BYTE_W +: GPIO_BYTE_W]);
    assign pin_out[k*GPIO_BYTE_W +: GPIO_BYTE_W] = data_b[k];
    assign pin_oe [k*GPIO_BYTE_W +: GPIO_BYTE_W] = dir_b[k];
  end

  // Read mux
  always_comb begin
    bus_rdata = '0;
    if (sel_leg) bus_rdata = lvl_b[LEG_RD];
    for (int k = 0; k < NBYTES; k++) begin
      if (sel_data[k]) bus_rdata = lvl_b[k];
      if (sel_dir[k])  bus_rdata = dir_b[k];
    end
  end
endmodule

// File: rtl/gpio16_port_chk.sv
module gpio16_port_chk #(
  parameter int unsigned LINE_W   = 16,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned LEG_OFS  = 'h400,
  parameter int unsigned DATA_OFS = 'h404
) (
  input logic              clk,
  input logic              rst_n,
  input logic              srst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_wdata,
  input logic              bus_we,
  input logic [7:0]        bus_rdata,
  input logic [LINE_W-1:0] pin_out,
  input logic [LINE_W-1:0] pin_oe
);
  localparam int unsigned NBYTES = LINE_W / 8;
  localparam int unsigned TOP    = DATA_OFS + 2 * NBYTES;

  logic decoded;
  assign decoded = (bus_addr == ADDR_W'(LEG_OFS)) ||
                   ((bus_addr >= ADDR_W'(DATA_OFS)) && (bus_addr < ADDR_W'(TOP)));

  // R1
  a_r1_reset_pins: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(srst_n) |-> (pin_out == '0) && (pin_oe == LINE_W'(8'hFF)));

  // R2
  a_r2_oe_follows_dir: assert property (@(posedge clk) disable iff (!rst_n)
    (srst_n && bus_we && bus_addr == ADDR_W'(DATA_OFS + NBYTES))
      |=> pin_oe[7:0] == $past(bus_wdata));

  // R3
  a_r3_out_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (srst_n && bus_we && bus_addr == ADDR_W'(DATA_OFS))
      |=> (pin_out[7:0] & pin_oe[7:0]) == ($past(bus_wdata) & $past(pin_oe[7:0])));

  // R4
  a_r4_input_hold: assert property (@(posedge clk) disable iff (!rst_n)
    srst_n |=> ((pin_out ^ $past(pin_out)) & ~$past(pin_oe)) == '0);

  // R6
  a_r6_legacy_write: assert property (@(posedge clk) disable iff (!rst_n)
    (srst_n && bus_we && bus_addr == ADDR_W'(LEG_OFS))
      |=> (pin_out[7:0] & pin_oe[7:0]) == ($past(bus_wdata) & $past(pin_oe[7:0])));

  // R8
  a_r8_undecoded_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !decoded |-> bus_rdata == 8'h00);

  a_r8_undecoded_nowrite: assert property (@(posedge clk) disable iff (!rst_n)
    (srst_n && bus_we && !decoded) |=> $stable(pin_out) && $stable(pin_oe));
endmodule

bind gpio16_port gpio16_port_chk #(
  .LINE_W(LINE_W), .ADDR_W(ADDR_W), .LEG_OFS(LEG_OFS), .DATA_OFS(DATA_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .srst_n(srst_n), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_rdata(bus_rdata),
  .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/gpio16_port_tb_top.sv
module gpio16_port_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic        bus_we;
  logic [7:0]  bus_rdata;
  logic [15:0] pin_out;
  logic [15:0] pin_oe;
  logic [15:0] pin_in;

  int checks = 0;
  int errs   = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio16_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .pin_out(pin_out),
    .pin_oe(pin_oe), .pin_in(pin_in)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [11:0] a, logic [7:0] exp);
    bus_addr = a;
    #1;
    chk(req, {8'h00, bus_rdata}, {8'h00, exp});
  endtask

  task automatic t_reset;
    chk("R1 pin_out", pin_out, 16'h0000);
    chk("R1 pin_oe", pin_oe, 16'h00FF);
    rd_chk("R1 data lo", 12'h404, 8'h00);
    rd_chk("R1 data hi", 12'h405, 8'h00);
    rd_chk("R1 dir lo", 12'h406, 8'hFF);
    rd_chk("R1 dir hi", 12'h407, 8'h00);
  endtask

  task automatic t_out_write;
    wr(12'h404, 8'hA5);
    chk("R3 pin_out lo", pin_out, 16'h00A5);
    rd_chk("R3 read back", 12'h404, 8'hA5);
  endtask

  task automatic t_input_ignore;
    wr(12'h405, 8'h3C);
    chk("R4 pin_out unchanged", pin_out, 16'h00A5);
    rd_chk("R4 read is pin", 12'h405, 8'h00);
    // turning the lines to outputs must expose the untouched stored zeros
    wr(12'h407, 8'hFF);
    chk("R4 stored stayed 0", pin_out, 16'h00A5);
    wr(12'h407, 8'h00);
  endtask

  task automatic t_sync;
    @(negedge clk);
    pin_in = 16'h5A00;
    @(negedge clk);
    rd_chk("R5 one edge old", 12'h405, 8'h00);
    @(negedge clk);
    rd_chk("R5 two edges new", 12'h405, 8'h5A);
  endtask

  task automatic t_dir_mix;
    wr(12'h407, 8'hF0);
    chk("R2 pin_oe", pin_oe, 16'hF0FF);
    rd_chk("R9 dir hi", 12'h407, 8'hF0);
    wr(12'h405, 8'hC3);
    chk("R4 partial write", pin_out, 16'hC0A5);
    rd_chk("R10 merged hi", 12'h405, 8'hCA);
    wr(12'h407, 8'h00);
    chk("R2 back to input", pin_oe, 16'h00FF);
  endtask

  task automatic t_legacy;
    wr(12'h400, 8'h3C);
    chk("R6 pin_out lo", pin_out[7:0], 16'h003C);
    rd_chk("R6 alias 404", 12'h404, 8'h3C);
    rd_chk("R7 legacy read", 12'h400, 8'h5A);
  endtask

  task automatic t_low_mix;
    wr(12'h406, 8'h0F);
    chk("R2 pin_oe lo", pin_oe, 16'h000F);
    wr(12'h404, 8'hFF);
    chk("R4 lo masked", pin_out[7:0], 16'h003F);
    rd_chk("R10 merged lo", 12'h404, 8'h0F);
    rd_chk("R9 dir lo", 12'h406, 8'h0F);
  endtask

  task automatic t_undecoded;
    rd_chk("R8 read 401", 12'h401, 8'h00);
    rd_chk("R8 read 408", 12'h408, 8'h00);
    rd_chk("R8 read 004", 12'h004, 8'h00);
    wr(12'h403, 8'hFF);
    wr(12'h006, 8'hFF);
    chk("R8 pin_out kept", pin_out, 16'hC03F);
    chk("R8 pin_oe kept", pin_oe, 16'h000F);
  endtask

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_we = 1'b0; pin_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_out_write();
    t_input_ignore();
    t_sync();
    t_dir_mix();
    t_legacy();
    t_low_mix();
    t_undecoded();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule